// File: doc/BRIEF.md
# DMA Read Burst Splitter

The block takes one host-memory read, given as a start address and a byte count, and cuts it into a series of burst read requests. Each request carries its own address and length and is offered on a valid/ready output. The block counts requests that are still in flight and stops issuing when that count reaches a configured ceiling. A completion pulse from the memory side retires one in-flight request. The block moves no data. It only schedules the request stream and reports when the whole read has been issued and retired.

Three configuration inputs shape the stream: a burst size select, an alignment-aware split enable, and the in-flight ceiling. The split mode is for memories that serve long bursts efficiently only from 128-byte-aligned addresses. When it is on and 128-byte bursts are selected, an unaligned address produces a short burst that ends at the next 64-byte line. After that the stream realigns. Configuration is expected to stay steady while a transfer is in progress.

Top module: `rd_burst_splitter`

## Requirements
- R1: Bursts are contiguous. The first burst starts at the command address, and their lengths add up to the command byte count. Each burst is the smaller of the bytes remaining and the limit. With split mode off, the limit is set by `cfg_burst_sel`: 0 gives 64 bytes, 1 gives 128 bytes, and 2 or 3 give 256 bytes. While `req_valid` is high and `req_ready` is low, the address and length hold steady.
- R2: With split mode on, selection 1, and an address whose bits [6:0] are not all zero, a burst never crosses a 64-byte boundary. Its limit is 64 minus address bits [5:0].
- R3: With split mode on and selection 1, a burst from a 128-byte-aligned address may be up to 128 bytes long.
- R4: Split mode has no effect when selection 0, 2 or 3 is in use.
- R5: The byte count may be any value from 1 upward, including values that are not a multiple of 4. The last burst carries whatever bytes remain.
- R6: `req_valid` is high exactly when bursts remain and the in-flight count is below the effective ceiling. A request counts as issued on a cycle where valid and ready are both high, and `cpl_pulse` retires one request.
- R7: The effective ceiling is `cfg_max_pend` clamped to 12. A value of 0 is treated as 1.
- R8: A `cpl_pulse` arriving while no request is in flight is ignored, and the count does not wrap.
- R9: One cycle after the state where no bytes remain and no requests are in flight, `done` is high for exactly one cycle. `idle` rises on that same cycle.
- R10: `cmd_start` is ignored while a transfer is in progress or when `cmd_len` is zero. While `idle` is high, `req_valid` is low.
- R11: After reset, `idle` is 1 and both `req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_max_pend | input | PEND_W | In-flight request ceiling (clamped to 12, 0 means 1) |
| cfg_burst_sel | input | 2 | Burst size: 0=64, 1=128, 2/3=256 bytes |
| cfg_split_en | input | 1 | Alignment-aware split mode enable |
| cmd_addr | input | ADDR_W | Transfer start address |
| cmd_len | input | LEN_W | Transfer byte count |
| cmd_start | input | 1 | Start strobe, taken only while idle |
| req_valid | output | 1 | Burst request offered |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | 9 | Burst length in bytes (1 to 256) |
| cpl_pulse | input | 1 | One request has completed |
| idle | output | 1 | No transfer in progress |
| done | output | 1 | One-cycle pulse at transfer end |

## Verification
The hardest state to reach is the in-flight count sitting at the clamped ceiling of 12. This needs a long stream, a consumer that always accepts, and completions held back for many cycles. The directed clamp case sets the ceiling field to 15, holds completions off for 30 cycles, and records the peak in-flight count. Random transfers cover the other cases. They use random byte counts and address offsets, combined with random ready and completion rates, including spurious completions while nothing is in flight. A bench-side reference of expected bursts and in-flight count checks every handshake and the `done` timing cycle by cycle.

// File: rtl/rbs_pkg.sv
// Shared constants and helpers for the read burst splitter.
package rbs_pkg;
    // Hard upper bound on in-flight requests, whatever the configuration says
    localparam int PEND_CAP = 12;
    // Width of a burst length; holds 1..256
    localparam int BLEN_W = 9;

    // Burst size in bytes for a burst size select code
    function automatic logic [BLEN_W-1:0] bsz_bytes(input logic [1:0] sel);
        case (sel)
            2'd0:    return BLEN_W'(64);
            2'd1:    return BLEN_W'(128);
            default: return BLEN_W'(256);
        endcase
    endfunction
endpackage

// File: rtl/rbs_len_calc.sv
// Combinational burst length for the current address and remaining bytes.
// Assumes LEN_W >= BLEN_W. Split rule applies only to the 128-byte select.
module rbs_len_calc
    import rbs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [6:0]        addr_lo,
    input  logic [LEN_W-1:0]  remain,
    input  logic [1:0]        sel,
    input  logic              split_en,
    output logic [BLEN_W-1:0] burst_len
);
    logic [BLEN_W-1:0] limit;
    logic [6:0]        to_line;

    // Bytes left before the next 64-byte line
    assign to_line = 7'd64 - {1'b0, addr_lo[5:0]};

    // Pick the per-burst limit, shortened for unaligned starts in split mode
    always_comb begin
        limit = bsz_bytes(sel);
        if (split_en && sel == 2'd1 && addr_lo != 7'd0)
            limit = BLEN_W'(to_line);
    end

    // Clip the limit to what is left of the transfer
    always_comb begin
        if (remain < LEN_W'(limit))
            burst_len = remain[BLEN_W-1:0];
        else
            burst_len = limit;
    end
endmodule

// File: rtl/rbs_pend_ctr.sv
// In-flight request counter with clamped ceiling.
// Assumes at most one issue and one retire per cycle. Retire at zero is dropped.
module rbs_pend_ctr
    import rbs_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] cfg_max,
    input  logic              issue,
    input  logic              retire,
    output logic [PEND_W-1:0] cnt,
    output logic              has_room
);
    localparam logic [PEND_W-1:0] CAP = PEND_W'(PEND_CAP);

    logic [PEND_W-1:0] eff_max;
    logic              retire_ok;

    // Clamp the configured ceiling to the cap and to at least one
    always_comb begin
        if (cfg_max > CAP)            eff_max = CAP;
        else if (cfg_max == '0)       eff_max = PEND_W'(1);
        else                          eff_max = cfg_max;
    end

    assign retire_ok = retire && (cnt != '0);
    assign has_room  = cnt < eff_max;

    // Track requests issued but not yet completed
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (issue && !retire_ok)
            cnt <= cnt + PEND_W'(1);
        else if (!issue && retire_ok)
            cnt <= cnt - PEND_W'(1);
    end
endmodule

// File: rtl/rbs_seq.sv
// Transfer sequencer: holds the running address and remaining bytes,
// accepts a start while idle, and signals completion.
// Assumes burst_len never exceeds remain.
module rbs_seq
    import rbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              issue,
    input  logic [BLEN_W-1:0] burst_len,
    input  logic              pend_zero,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  remain,
    output logic              busy,
    output logic              done
);
    // Advance the transfer and close it once everything has retired
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            cur_addr <= '0;
            remain   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (cmd_start && cmd_len != '0) begin
                    busy     <= 1'b1;
                    cur_addr <= cmd_addr;
                    remain   <= cmd_len;
                end
            end else if (issue) begin
                cur_addr <= cur_addr + ADDR_W'(burst_len);
                remain   <= remain - LEN_W'(burst_len);
            end else if (remain == '0 && pend_zero) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rd_burst_splitter_chk.sv
// Property checker for the read burst splitter, attached by bind.
module rd_burst_splitter_chk
    import rbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PEND_W-1:0] cfg_max_pend,
    input logic [1:0]        cfg_burst_sel,
    input logic              cfg_split_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [BLEN_W-1:0] req_len,
    input logic              idle,
    input logic              done,
    input logic [PEND_W-1:0] pend_cnt
);
    logic [PEND_W-1:0] lim_c;

    // Independent view of the effective ceiling
    always_comb begin
        lim_c = cfg_max_pend;
        if (cfg_max_pend > PEND_W'(12)) lim_c = PEND_W'(12);
        if (cfg_max_pend == '0)         lim_c = PEND_W'(1);
    end

    AST_PEND_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= lim_c) else $error("pend over limit"); // R6
    AST_PEND_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= PEND_W'(12)) else $error("pend over cap"); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len))
        else $error("request changed while stalled"); // R1
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_len != '0 && req_len <= BLEN_W'(256))
        else $error("bad burst length"); // R1
    AST_SPLIT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cfg_split_en && cfg_burst_sel == 2'd1 && req_addr[6:0] != 7'd0
        |-> ({4'd0, req_addr[5:0]} + {1'b0, req_len}) <= 10'd64)
        else $error("split burst crosses line"); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done too long"); // R9
    AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idle && pend_cnt == '0) else $error("done while busy"); // R9
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !req_valid) else $error("request while idle"); // R10
endmodule

bind rd_burst_splitter rd_burst_splitter_chk #(.ADDR_W(ADDR_W), .PEND_W(PEND_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_max_pend(cfg_max_pend), .cfg_burst_sel(cfg_burst_sel),
    .cfg_split_en(cfg_split_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .idle(idle), .done(done), .pend_cnt(pend_cnt)
);

// File: rtl/rd_burst_splitter.sv
// Read burst splitter top: cuts one read into bursts under a size rule
// and an in-flight ceiling. Assumes configuration is steady during a transfer.
module rd_burst_splitter
    import rbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] cfg_max_pend,
    input  logic [1:0]        cfg_burst_sel,
    input  logic              cfg_split_en,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_start,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BLEN_W-1:0] req_len,
    input  logic              cpl_pulse,
    output logic              idle,
    output logic              done
);
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [BLEN_W-1:0] burst_len;
    logic [PEND_W-1:0] pend_cnt;
    logic              has_room;
    logic              busy;
    logic              issue;

    // Offer a burst whenever bytes remain and the ceiling allows
    assign req_valid = busy && (remain != '0) && has_room;
    assign issue     = req_valid && req_ready;
    assign req_addr  = cur_addr;
    assign req_len   = burst_len;
    assign idle      = !busy;

    rbs_len_calc #(.LEN_W(LEN_W)) len_i (
        .addr_lo  (cur_addr[6:0]),
        .remain   (remain),
        .sel      (cfg_burst_sel),
        .split_en (cfg_split_en),
        .burst_len(burst_len)
    );

    rbs_pend_ctr #(.PEND_W(PEND_W)) pend_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_max (cfg_max_pend),
        .issue   (issue),
        .retire  (cpl_pulse),
        .cnt     (pend_cnt),
        .has_room(has_room)
    );

    rbs_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_start(cmd_start),
        .cmd_addr (cmd_addr),
        .cmd_len  (cmd_len),
        .issue    (issue),
        .burst_len(burst_len),
        .pend_zero(pend_cnt == '0),
        .cur_addr (cur_addr),
        .remain   (remain),
        .busy     (busy),
        .done     (done)
    );
endmodule

// File: tb/rd_burst_splitter_tb_top.sv
module rd_burst_splitter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_max_pend = 4'd4;
    logic [1:0]  cfg_burst_sel = 2'd0;
    logic        cfg_split_en = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        cmd_start = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [8:0]  req_len;
    logic        cpl_pulse = 1'b0;
    logic        idle;
    logic        done;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int outst, peak, lim_m;
    longint exp_addr;
    int exp_rem;

    always #(CLK_PERIOD/2) clk = ~clk;

    rd_burst_splitter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_max_pend(cfg_max_pend), .cfg_burst_sel(cfg_burst_sel),
        .cfg_split_en(cfg_split_en), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_start(cmd_start), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .cpl_pulse(cpl_pulse),
        .idle(idle), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected burst length from the size and split rules
    function automatic int nxt_len(input longint a, input int rem, input logic [1:0] sel,
                                   input logic split);
        int lim;
        lim = (sel == 2'd0) ? 64 : (sel == 2'd1) ? 128 : 256;
        if (split && sel == 2'd1 && (a % 128) != 0) lim = 64 - int'(a % 64);
        return (rem < lim) ? rem : lim;
    endfunction

    function automatic int eff_lim(input logic [3:0] m);
        if (m > 4'd12) return 12;
        if (m == 4'd0) return 1;
        return int'(m);
    endfunction

    // Run one transfer against the reference; hold delays completions
    task automatic run_xfer(input logic [31:0] a, input int n, input int rdy_pct,
                            input int cpl_pct, input int hold, input bit poke);
        bit prev_fin, fin, exp_v, hs;
        int it;
        @(negedge clk);
        cmd_addr = a; cmd_len = 16'(n); cmd_start = 1'b1;
        exp_addr = a; exp_rem = n; outst = 0; peak = 0;
        lim_m = eff_lim(cfg_max_pend);
        prev_fin = 1'b0; fin = 1'b0; it = 0;
        while (!fin && it < 5000) begin
            @(negedge clk);
            cmd_start = 1'b0;
            if (poke && it == 2) begin   // R10: start while busy must be ignored
                cmd_start = 1'b1; cmd_addr = 32'h5000_0000; cmd_len = 16'd8;
            end
            req_ready = (($urandom % 100) < rdy_pct);
            cpl_pulse = (it >= hold) && (($urandom % 100) < cpl_pct);
            #1;
            chk(done == prev_fin, "R9 done timing", done, prev_fin);
            if (done) begin
                fin = 1'b1;
                chk(idle == 1'b1, "R9 idle with done", idle, 1);
            end else begin
                exp_v = (exp_rem != 0) && (outst < lim_m);
                chk(req_valid == exp_v, "R6 valid vs ceiling", req_valid, exp_v);
                hs = exp_v && req_ready;
                if (hs && req_valid) begin
                    int e;
                    e = nxt_len(exp_addr, exp_rem, cfg_burst_sel, cfg_split_en);
                    chk(req_addr == 32'(exp_addr), "R1/R2/R3/R4 burst addr", req_addr, exp_addr);
                    chk(int'(req_len) == e, "R1/R2/R3/R4/R5 burst len", req_len, e);
                    exp_addr += e; exp_rem -= e;
                end
                prev_fin = (exp_rem == 0) && (outst == 0);
                if (hs) outst++;
                if (cpl_pulse && (outst - (hs ? 1 : 0)) > 0) outst--;  // R8: retire at zero dropped
                if (outst > peak) peak = outst;
                prev_fin = prev_fin && !hs;
            end
            it++;
        end
        if (!fin) chk(1'b0, "R9 transfer never finished", 0, 1);
        @(negedge clk);
        req_ready = 1'b0; cpl_pulse = 1'b0; cmd_start = 1'b0;
        #1;
        chk(done == 1'b0, "R9 done single cycle", done, 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(idle == 1'b1, "R11 idle after reset", idle, 1);
        chk(req_valid == 1'b0, "R11 no request after reset", req_valid, 0);
        chk(done == 1'b0, "R11 no done after reset", done, 0);

        // R4: split ignored at 64-byte size
        cfg_burst_sel = 2'd0; cfg_split_en = 1'b1; cfg_max_pend = 4'd3;
        run_xfer(32'h0000_1010, 200, 70, 50, 0, 0);
        // R2 then R3: unaligned head, then aligned 128s
        cfg_burst_sel = 2'd1;
        run_xfer(32'h0000_1070, 300, 80, 60, 0, 0);
        // R1: split off gives full 128s from unaligned address
        cfg_split_en = 1'b0;
        run_xfer(32'h0000_0070, 300, 80, 60, 0, 0);
        // R4/R5: 256 with split on, odd count
        cfg_burst_sel = 2'd2; cfg_split_en = 1'b1;
        run_xfer(32'h0000_0023, 513, 60, 40, 0, 0);
        // R7: clamp of 15 to 12
        cfg_burst_sel = 2'd0; cfg_max_pend = 4'd15;
        run_xfer(32'h0000_2000, 64*20, 100, 100, 30, 0);
        chk(peak == 12, "R7 peak in-flight clamped", peak, 12);
        // R7: zero means one
        cfg_max_pend = 4'd0;
        run_xfer(32'h0000_3000, 64*4, 100, 100, 5, 0);
        chk(peak == 1, "R7 zero ceiling acts as one", peak, 1);
        // R10: zero length start ignored
        @(negedge clk);
        cmd_len = 16'd0; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(idle == 1'b1, "R10 zero length ignored", idle, 1);
        chk(req_valid == 1'b0, "R10 zero length no request", req_valid, 0);
        // R8: spurious completions while idle must not wrap the count
        cpl_pulse = 1'b1;
        repeat (3) @(negedge clk);
        cpl_pulse = 1'b0;
        cfg_max_pend = 4'd1;
        run_xfer(32'h0000_4000, 100, 100, 50, 0, 0);
        // R10: start while busy ignored
        cfg_max_pend = 4'd2;
        run_xfer(32'h0000_4400, 400, 50, 50, 0, 1);

        // Random transfers
        for (int k = 0; k < 40; k++) begin
            logic [31:0] ra;
            int rn;
            cfg_burst_sel = 2'($urandom % 4);
            cfg_split_en  = 1'($urandom % 2);
            cfg_max_pend  = 4'($urandom % 16);
            ra = $urandom;
            rn = 1 + int'($urandom % 1500);
            run_xfer(ra, rn, 30 + int'($urandom % 71), 20 + int'($urandom % 81),
                     int'($urandom % 10), 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule